// File: doc/BRIEF.md
# Emulation Break Condition Unit

This block sits beside an emulated CPU core and decides when the running program must stop. It watches instruction fetches, data memory accesses, the register file after each instruction, an external break pin and a host "stop now" strobe. Each of nine break sources can be enabled on its own. A single break request goes up when any enabled source fires.

Two of the sources are more elaborate. The sequence break fires only after three programmed fetch addresses have been seen in order, with a pass count on the third. The data break matches an inclusive address window, a masked data value and a maskable read/write direction. The unit also reports memory-map faults: a fetch beyond the end of program memory, a data access that falls outside both the RAM and I/O windows, a write into a read-only window, and a stack access outside the stack window. The top edge of the stack window is widened by three locations to allow for prefetch.

The break request is held off while an interrupt acknowledge is in progress, so the core stops at the handler entry. A sticky cause vector records which sources fired, and the host clears it. A stop status output reports both a suspended core and a taken break.

Top module: `brk_cond_unit`

## Requirements
- R1: When `fetchValid` is high and the program-address flag at `fetchPc` is set (written through `bpWr`), `brkReq` goes high at the next clock edge, and cause bit 0 is set.
- R2: The sequence source fires only after a fetch of `seqAddr1`, then a later fetch of `seqAddr2`, then `seqPass` fetches of `seqAddr3`; a pass count of 0 acts as 1. Out-of-order fetches do not advance it. Its cause bit is 1.
- R3: The sequence source returns to waiting for `seqAddr1` when `runStart` is pulsed and after it fires.
- R4: The data source fires on a `memValid` access that meets three conditions: `dAddrLo <= memAddr <= dAddrHi`; the bits of `memData` selected by `dDataMask` (1 = compare) equal `dData`; and, when `dRwMask` is 1, `memWr` equals `dRw` (1 = write). Its cause bit is 2.
- R5: The register source fires on `instDone` when `regState` equals `regVal` in every bit that `regMask` sets. The register vector is packed as {A[3:0], B[3:0], X[7:0], Y[7:0], E, I, C, Z}, with A at the most significant end. Its cause bit is 3.
- R6: The external pin passes through two synchronizing flops. It fires once, when the synchronized level has been low for `extMinCyc` consecutive cycles (0 acts as 1); shorter low pulses are ignored. Its cause bit is 4.
- R7: A `forceBrk` pulse fires the host source, cause bit 4+1 = 5.
- R8: A fetch with `fetchPc > romTop`, or a data access outside both [`ramLo`,`ramHi`] and [`ioLo`,`ioHi`], sets cause bit 6. A write inside [`roLo`,`roHi`] sets cause bit 7.
- R9: A stack access (`stackAcc` with `memValid`) at an address below `stkLo` or above `stkHi + 3` sets cause bit 8.
- R10: A source whose `srcEn` bit is 0 neither raises `brkReq` nor sets its cause bit.
- R11: While `intAckN` is low, `brkReq` stays low. A source that fired meanwhile raises `brkReq` at the first edge at which `intAckN` is high.
- R12: `brkReq` stays high until `runStart`, and is low after the edge that samples `runStart`. While `brkReq` is high, source events are ignored.
- R13: `stopN` is low exactly when `haltSleep` or `brkReq` is high.
- R14: `brkCause` bits are sticky. They survive `runStart` and are cleared only by `statusClr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runStart | input | 1 | Pulse at the start of a run |
| statusClr | input | 1 | Host clear of the cause vector |
| srcEn | input | 9 | Per-source enable |
| bpWr | input | 1 | Write strobe for the address flag memory |
| bpWrAddr | input | 8 | Flag memory address |
| bpWrFlag | input | 1 | Flag value to write |
| seqAddr1 | input | 8 | Sequence first address |
| seqAddr2 | input | 8 | Sequence second address |
| seqAddr3 | input | 8 | Sequence last address |
| seqPass | input | 8 | Pass count on the last address |
| dAddrLo | input | 8 | Data window low bound |
| dAddrHi | input | 8 | Data window high bound |
| dData | input | 4 | Data compare value |
| dDataMask | input | 4 | Data compare mask, 1 = compare |
| dRw | input | 1 | Direction to match, 1 = write |
| dRwMask | input | 1 | 1 = compare the direction |
| regVal | input | 28 | Register compare value |
| regMask | input | 28 | Register compare mask |
| extMinCyc | input | 16 | Minimum low time of the pin, in cycles |
| romTop | input | 8 | Last valid program address |
| ramLo | input | 8 | RAM window low bound |
| ramHi | input | 8 | RAM window high bound |
| ioLo | input | 8 | I/O window low bound |
| ioHi | input | 8 | I/O window high bound |
| roLo | input | 8 | Read-only window low bound |
| roHi | input | 8 | Read-only window high bound |
| stkLo | input | 8 | Stack window low bound |
| stkHi | input | 8 | Stack window high bound before widening |
| fetchValid | input | 1 | Instruction fetch strobe |
| fetchPc | input | 8 | Address being fetched |
| memValid | input | 1 | Data access strobe |
| memWr | input | 1 | Access is a write |
| memAddr | input | 8 | Data address |
| memData | input | 4 | Data value |
| stackAcc | input | 1 | Access is a stack operation |
| instDone | input | 1 | Instruction completed |
| regState | input | 28 | Register state after the instruction |
| extBrkN | input | 1 | External break pin, active low |
| forceBrk | input | 1 | Host forced break pulse |
| intAckN | input | 1 | Interrupt acknowledge, active low |
| haltSleep | input | 1 | Core halted or sleeping |
| brkReq | output | 1 | Break request |
| brkCause | output | 9 | Sticky cause vector |
| stopN | output | 1 | Stop status, active low |

## Verification
The assertions assume that `runStart` and a source event are never asserted in the same cycle. They also assume that configuration inputs stay still while a sequence is counting, because the pass-count comparison is computed against the live `seqPass`. The stimulus changes configuration only between runs, each opened by a `runStart` cycle with quiet CPU strobes. It drives the pin and the interrupt acknowledge only from directed steps with known cycle counts. The random phases vary the data and register compare settings one access per run, so at most one event can fire per run.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NSRC     = 9;
  localparam int SRC_PC   = 0;
  localparam int SRC_SEQ  = 1;
  localparam int SRC_DATA = 2;
  localparam int SRC_REG  = 3;
  localparam int SRC_PIN  = 4;
  localparam int SRC_HOST = 5;
  localparam int SRC_MAP  = 6;
  localparam int SRC_WP   = 7;
  localparam int SRC_STK  = 8;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seq_ctl_t;

  typedef struct packed {
    logic pcHit;
    logic s1Hit;
    logic s2Hit;
    logic s3Hit;
    logic s3Last;
    logic dataHit;
    logic regHit;
    logic mapHit;
    logic wpHit;
    logic stkHit;
  } match_t;

  typedef enum logic [1:0] {SEQ_WAIT1, SEQ_WAIT2, SEQ_COUNT} seq_state_e;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4,
  parameter int REGV_W = 28,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic              bpWr,
  input  logic [PC_W-1:0]   bpWrAddr,
  input  logic              bpWrFlag,
  input  logic [PC_W-1:0]   seqAddr1,
  input  logic [PC_W-1:0]   seqAddr2,
  input  logic [PC_W-1:0]   seqAddr3,
  input  logic [CNT_W-1:0]  seqPass,
  input  logic [PC_W-1:0]   romTop,
  input  logic              fetchValid,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [ADDR_W-1:0] dAddrLo,
  input  logic [ADDR_W-1:0] dAddrHi,
  input  logic [DATA_W-1:0] dData,
  input  logic [DATA_W-1:0] dDataMask,
  input  logic              dRw,
  input  logic              dRwMask,
  input  logic [ADDR_W-1:0] ramLo,
  input  logic [ADDR_W-1:0] ramHi,
  input  logic [ADDR_W-1:0] ioLo,
  input  logic [ADDR_W-1:0] ioHi,
  input  logic [ADDR_W-1:0] roLo,
  input  logic [ADDR_W-1:0] roHi,
  input  logic [ADDR_W-1:0] stkLo,
  input  logic [ADDR_W-1:0] stkHi,
  input  logic              memValid,
  input  logic              memWr,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  input  logic              stackAcc,
  input  logic              instDone,
  input  logic [REGV_W-1:0] regState,
  input  logic [REGV_W-1:0] regVal,
  input  logic [REGV_W-1:0] regMask,
  output match_t            m
);
  localparam int PC_DEPTH  = 1 << PC_W;
  localparam int STK_SLACK = 3;

  logic [PC_DEPTH-1:0] bpFlags;
  logic [CNT_W-1:0]    passCnt;
  logic [CNT_W:0]      passEff;
  logic [ADDR_W:0]     stkTopWide;
  logic                inRam, inIo, inRo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bpFlags <= '0;
    else if (bpWr) bpFlags[bpWrAddr] <= bpWrFlag;
  end

  // pass counter on the last sequence address, stepped by the control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) passCnt <= '0;
    else if (ctl.cntClr) passCnt <= '0;
    else if (ctl.cntInc) passCnt <= passCnt + 1'b1;
  end

  assign passEff    = (seqPass == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, seqPass};
  assign stkTopWide = {1'b0, stkHi} + (ADDR_W + 1)'(STK_SLACK);
  assign inRam = (memAddr >= ramLo) && (memAddr <= ramHi);
  assign inIo  = (memAddr >= ioLo) && (memAddr <= ioHi);
  assign inRo  = (memAddr >= roLo) && (memAddr <= roHi);

  always_comb begin
    m.pcHit   = fetchValid && bpFlags[fetchPc];
    m.s1Hit   = fetchValid && (fetchPc == seqAddr1);
    m.s2Hit   = fetchValid && (fetchPc == seqAddr2);
    m.s3Hit   = fetchValid && (fetchPc == seqAddr3);
    m.s3Last  = ({1'b0, passCnt} + 1'b1) >= passEff;
    m.dataHit = memValid && (memAddr >= dAddrLo) && (memAddr <= dAddrHi)
                && (((memData ^ dData) & dDataMask) == '0)
                && (!dRwMask || (memWr == dRw));
    m.regHit  = instDone && (((regState ^ regVal) & regMask) == '0);
    m.mapHit  = (fetchValid && (fetchPc > romTop)) || (memValid && !inRam && !inIo);
    m.wpHit   = memValid && memWr && inRo;
    m.stkHit  = memValid && stackAcc
                && ((memAddr < stkLo) || ({1'b0, memAddr} > stkTopWide));
  end

  // R2: the control never clears and advances the pass counter together
  a_r2_ctl_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.cntClr && ctl.cntInc));
  // R2: a cleared counter reads zero on the following cycle
  a_r2_cnt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClr |=> (passCnt == '0));
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
#(
  parameter int PULSE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runStart,
  input  logic               statusClr,
  input  logic [NSRC-1:0]    srcEn,
  input  logic               intAckN,
  input  logic               extBrkN,
  input  logic [PULSE_W-1:0] extMinCyc,
  input  logic               forceBrk,
  input  logic               fetchValid,
  input  match_t             m,
  output seq_ctl_t           ctl,
  output logic               brkReq,
  output logic [NSRC-1:0]    brkCause
);
  seq_state_e         seqQ, seqNxt;
  logic               seqFire;
  logic               pinS1, pinS2, pinFire;
  logic [PULSE_W-1:0] lowCnt, minEff;
  logic               brkQ, pendQ;
  logic [NSRC-1:0]    rawHit, hitEn;

  // sequence tracker: addr1 -> addr2 -> addr3 counted
  always_comb begin
    seqNxt = seqQ; ctl = '0; seqFire = 1'b0;
    if (runStart) begin
      seqNxt = SEQ_WAIT1; ctl.cntClr = 1'b1;
    end else if (!brkQ && fetchValid) begin
      case (seqQ)
        SEQ_WAIT1: if (m.s1Hit) seqNxt = SEQ_WAIT2;
        SEQ_WAIT2: if (m.s2Hit) begin seqNxt = SEQ_COUNT; ctl.cntClr = 1'b1; end
        SEQ_COUNT: if (m.s3Hit) begin
          if (m.s3Last) begin seqFire = 1'b1; seqNxt = SEQ_WAIT1; ctl.cntClr = 1'b1; end
          else ctl.cntInc = 1'b1;
        end
        default: seqNxt = SEQ_WAIT1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqQ <= SEQ_WAIT1;
    else seqQ <= seqNxt;
  end

  // external pin: synchronize, then qualify the low time
  assign minEff  = (extMinCyc == '0) ? PULSE_W'(1) : extMinCyc;
  assign pinFire = !pinS2 && (lowCnt == minEff - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS1 <= 1'b1; pinS2 <= 1'b1; lowCnt <= '0;
    end else begin
      pinS1 <= extBrkN;
      pinS2 <= pinS1;
      if (pinS2) lowCnt <= '0;
      else if (lowCnt != {PULSE_W{1'b1}}) lowCnt <= lowCnt + 1'b1;
    end
  end

  always_comb begin
    rawHit           = '0;
    rawHit[SRC_PC]   = m.pcHit;
    rawHit[SRC_SEQ]  = seqFire;
    rawHit[SRC_DATA] = m.dataHit;
    rawHit[SRC_REG]  = m.regHit;
    rawHit[SRC_PIN]  = pinFire;
    rawHit[SRC_HOST] = forceBrk;
    rawHit[SRC_MAP]  = m.mapHit;
    rawHit[SRC_WP]   = m.wpHit;
    rawHit[SRC_STK]  = m.stkHit;
    hitEn = (brkQ || runStart) ? '0 : (rawHit & srcEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brkQ <= 1'b0; pendQ <= 1'b0; brkCause <= '0;
    end else begin
      brkCause <= (statusClr ? '0 : brkCause) | hitEn;
      if (runStart) begin
        brkQ <= 1'b0; pendQ <= 1'b0;
      end else begin
        pendQ <= pendQ | (|hitEn);
        brkQ  <= brkQ | (intAckN && (pendQ || (|hitEn)));
      end
    end
  end

  assign brkReq = brkQ;

  a_r3_seq_legal: assert property (@(posedge clk) disable iff (!rstN)
    seqQ != 2'b11);
  a_r10_enabled_hit_breaks: assert property (@(posedge clk) disable iff (!rstN)
    ((|hitEn) && intAckN && !runStart) |=> brkQ);
  a_r11_defer: assert property (@(posedge clk) disable iff (!rstN)
    (!intAckN && !brkQ) |=> !brkQ);
  a_r12_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    runStart |=> !brkQ);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (brkQ && !runStart) |=> brkQ);
  a_r14_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !statusClr |=> ((brkCause & $past(brkCause)) == $past(brkCause)));
endmodule

// File: rtl/brk_cond_unit.sv
module brk_cond_unit
  import brk_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 4,
  parameter int ACC_W   = 4,
  parameter int IDX_W   = 8,
  parameter int CNT_W   = 8,
  parameter int PULSE_W = 16,
  localparam int REGV_W = 2 * ACC_W + 2 * IDX_W + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runStart,
  input  logic               statusClr,
  input  logic [NSRC-1:0]    srcEn,
  input  logic               bpWr,
  input  logic [PC_W-1:0]    bpWrAddr,
  input  logic               bpWrFlag,
  input  logic [PC_W-1:0]    seqAddr1,
  input  logic [PC_W-1:0]    seqAddr2,
  input  logic [PC_W-1:0]    seqAddr3,
  input  logic [CNT_W-1:0]   seqPass,
  input  logic [ADDR_W-1:0]  dAddrLo,
  input  logic [ADDR_W-1:0]  dAddrHi,
  input  logic [DATA_W-1:0]  dData,
  input  logic [DATA_W-1:0]  dDataMask,
  input  logic               dRw,
  input  logic               dRwMask,
  input  logic [REGV_W-1:0]  regVal,
  input  logic [REGV_W-1:0]  regMask,
  input  logic [PULSE_W-1:0] extMinCyc,
  input  logic [PC_W-1:0]    romTop,
  input  logic [ADDR_W-1:0]  ramLo,
  input  logic [ADDR_W-1:0]  ramHi,
  input  logic [ADDR_W-1:0]  ioLo,
  input  logic [ADDR_W-1:0]  ioHi,
  input  logic [ADDR_W-1:0]  roLo,
  input  logic [ADDR_W-1:0]  roHi,
  input  logic [ADDR_W-1:0]  stkLo,
  input  logic [ADDR_W-1:0]  stkHi,
  input  logic               fetchValid,
  input  logic [PC_W-1:0]    fetchPc,
  input  logic               memValid,
  input  logic               memWr,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic [DATA_W-1:0]  memData,
  input  logic               stackAcc,
  input  logic               instDone,
  input  logic [REGV_W-1:0]  regState,
  input  logic               extBrkN,
  input  logic               forceBrk,
  input  logic               intAckN,
  input  logic               haltSleep,
  output logic               brkReq,
  output logic [NSRC-1:0]    brkCause,
  output logic               stopN
);
  seq_ctl_t ctl;
  match_t   m;

  brk_datapath #(.PC_W(PC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .REGV_W(REGV_W), .CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .ctl, .bpWr, .bpWrAddr, .bpWrFlag,
    .seqAddr1, .seqAddr2, .seqAddr3, .seqPass, .romTop,
    .fetchValid, .fetchPc, .dAddrLo, .dAddrHi, .dData, .dDataMask,
    .dRw, .dRwMask, .ramLo, .ramHi, .ioLo, .ioHi, .roLo, .roHi,
    .stkLo, .stkHi, .memValid, .memWr, .memAddr, .memData, .stackAcc,
    .instDone, .regState, .regVal, .regMask, .m);

  brk_control #(.PULSE_W(PULSE_W)) u_ctl (
    .clk, .rstN, .runStart, .statusClr, .srcEn, .intAckN, .extBrkN,
    .extMinCyc, .forceBrk, .fetchValid, .m, .ctl, .brkReq, .brkCause);

  assign stopN = !(haltSleep || brkReq);
endmodule

// File: tb/sim_brk_cond_unit.sv
`timescale 1ns/1ps
module sim_brk_cond_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic runStart, statusClr, bpWr, bpWrFlag, dRw, dRwMask;
  logic [8:0] srcEn, brkCause;
  logic [7:0] bpWrAddr, seqAddr1, seqAddr2, seqAddr3, seqPass, dAddrLo, dAddrHi;
  logic [3:0] dData, dDataMask, memData;
  logic [27:0] regVal, regMask, regState;
  logic [15:0] extMinCyc;
  logic [7:0] romTop, ramLo, ramHi, ioLo, ioHi, roLo, roHi, stkLo, stkHi, fetchPc, memAddr;
  logic fetchValid, memValid, memWr, stackAcc, instDone, extBrkN, forceBrk, intAckN, haltSleep;
  logic brkReq, stopN;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  brk_cond_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask

  task automatic quiet;
    fetchValid = 0; memValid = 0; memWr = 0; stackAcc = 0; instDone = 0;
    forceBrk = 0; runStart = 0; statusClr = 0; bpWr = 0;
  endtask

  task automatic newRun(input logic [8:0] en);
    quiet(); srcEn = en; runStart = 1; statusClr = 1; step(); quiet();
  endtask

  task automatic fetch(input logic [7:0] pc);
    fetchValid = 1; fetchPc = pc; step(); fetchValid = 0;
  endtask

  task automatic access(input logic [7:0] a, input logic wr, input logic [3:0] d, input logic stk);
    memValid = 1; memAddr = a; memWr = wr; memData = d; stackAcc = stk; step();
    memValid = 0; memWr = 0; stackAcc = 0;
  endtask

  function automatic bit dataExp(input logic [7:0] lo, hi, a, input logic [3:0] d, msk, md,
                                 input logic rw, rwm, wr);
    return (a >= lo) && (a <= hi) && (((md ^ d) & msk) == 0) && (!rwm || (wr == rw));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd19));
    quiet(); srcEn = '0; bpWrAddr = 0; bpWrFlag = 0;
    seqAddr1 = 8'h10; seqAddr2 = 8'h20; seqAddr3 = 8'h30; seqPass = 3;
    dAddrLo = 0; dAddrHi = 0; dData = 0; dDataMask = 0; dRw = 0; dRwMask = 0;
    regVal = 0; regMask = 0; regState = 0; extMinCyc = 4;
    romTop = 8'hEF; ramLo = 8'h00; ramHi = 8'h7F; ioLo = 8'hF0; ioHi = 8'hFF;
    roLo = 8'h60; roHi = 8'h6F; stkLo = 8'h40; stkHi = 8'h4F;
    fetchPc = 0; memAddr = 0; memData = 0; extBrkN = 1; intAckN = 1; haltSleep = 0;
    repeat (3) step();
    rstN = 1; step();
    chk(brkReq == 0 && brkCause == 0 && stopN == 1, "reset", {brkReq, brkCause, stopN}, 32'h1);

    // R1 address flag break
    bpWr = 1; bpWrAddr = 8'h55; bpWrFlag = 1; step(); bpWr = 0;
    newRun(9'h001);
    fetch(8'h54); chk(brkReq == 0, "R1 other pc", brkReq, 0);
    fetch(8'h55); chk(brkReq == 1 && brkCause == 9'h001, "R1 flag hit", {brkReq, brkCause}, 32'h201);

    // R13 stop output
    chk(stopN == 0, "R13 break", stopN, 0);
    newRun(9'h000); haltSleep = 1; #1;
    chk(stopN == 0, "R13 halt", stopN, 0);
    haltSleep = 0; #1; chk(stopN == 1, "R13 run", stopN, 1);

    // R2 ordered sequence with pass count 3
    newRun(9'h002);
    fetch(8'h30); fetch(8'h20); fetch(8'h10); fetch(8'h30); fetch(8'h20);
    fetch(8'h30); fetch(8'h30);
    chk(brkReq == 0, "R2 before last pass", brkReq, 0);
    fetch(8'h30);
    chk(brkReq == 1 && brkCause == 9'h002, "R2 third pass", {brkReq, brkCause}, 32'h202);
    // R2 pass count zero acts as one
    seqPass = 0; newRun(9'h002);
    fetch(8'h10); fetch(8'h20); fetch(8'h30);
    chk(brkReq == 1, "R2 pass zero", brkReq, 1);
    // R3 run start returns the tracker to the first address
    newRun(9'h002); fetch(8'h10); fetch(8'h20);
    newRun(9'h002); fetch(8'h30); fetch(8'h30);
    chk(brkReq == 0, "R3 restart", brkReq, 0);
    fetch(8'h10); fetch(8'h20); fetch(8'h30);
    chk(brkReq == 1, "R3 fresh sequence", brkReq, 1);

    // R4 directed: direction mask
    dAddrLo = 8'h20; dAddrHi = 8'h2F; dData = 4'hA; dDataMask = 4'hF; dRw = 1; dRwMask = 1;
    newRun(9'h004); access(8'h25, 0, 4'hA, 0);
    chk(brkReq == 0, "R4 read masked out", brkReq, 0);
    access(8'h2F, 1, 4'hA, 0);
    chk(brkReq == 1 && brkCause == 9'h004, "R4 write at top", {brkReq, brkCause}, 32'h204);
    // R4 random
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, b, ad; logic [3:0] md; logic wr; bit e;
      a = 8'($urandom_range(0, 127)); b = 8'($urandom_range(0, 127));
      dAddrLo = (a < b) ? a : b; dAddrHi = (a < b) ? b : a;
      dData = 4'($urandom); dDataMask = 4'($urandom); dRw = 1'($urandom); dRwMask = 1'($urandom);
      ad = 8'($urandom_range(0, 127)); md = 4'($urandom); wr = 1'($urandom);
      if (i % 3 == 0) begin ad = dAddrLo; md = dData ^ (4'($urandom) & ~dDataMask); end
      e = dataExp(dAddrLo, dAddrHi, ad, dData, dDataMask, md, dRw, dRwMask, wr);
      newRun(9'h004); access(ad, wr, md, 0);
      chk(brkReq == e && brkCause == (e ? 9'h004 : 9'h000), "R4 random",
          {brkReq, brkCause}, {e, e ? 9'h004 : 9'h000});
    end

    // R5 register compare, random with biased matches
    for (int i = 0; i < 40; i++) begin
      logic [27:0] st; bit e;
      regVal = 28'($urandom); regMask = 28'($urandom);
      st = (i % 2 == 0) ? (regVal ^ (28'($urandom) & ~regMask)) : 28'($urandom);
      if (i == 1) begin regMask = 28'h000_0004; st = regVal ^ 28'h4; end
      e = ((st ^ regVal) & regMask) == 0;
      newRun(9'h008); regState = st; instDone = 1; step(); instDone = 0;
      chk(brkReq == e && brkCause == (e ? 9'h008 : 9'h000), "R5 register",
          {brkReq, brkCause}, {e, e ? 9'h008 : 9'h000});
    end

    // R6 external pin
    newRun(9'h010);
    extBrkN = 0; repeat (3) step(); extBrkN = 1; repeat (8) step();
    chk(brkReq == 0, "R6 short pulse", brkReq, 0);
    extBrkN = 0; repeat (5) step();
    chk(brkReq == 0, "R6 not yet", brkReq, 0);
    step();
    chk(brkReq == 1 && brkCause == 9'h010, "R6 qualified", {brkReq, brkCause}, 32'h210);
    newRun(9'h010); repeat (10) step();
    chk(brkReq == 0, "R6 once per low", brkReq, 0);
    extBrkN = 1; repeat (3) step();

    // R11 interrupt acknowledge deferral with forced break (R7)
    newRun(9'h020); intAckN = 0;
    forceBrk = 1; step(); forceBrk = 0;
    chk(brkReq == 0, "R11 held", brkReq, 0);
    step(); chk(brkReq == 0, "R11 still held", brkReq, 0);
    intAckN = 1; step();
    chk(brkReq == 1 && brkCause == 9'h020, "R7 R11 released", {brkReq, brkCause}, 32'h220);

    // R12 events ignored during break, R14 sticky across run start
    srcEn = 9'h1FF; access(8'hA0, 0, 0, 0);
    chk(brkCause == 9'h020, "R12 ignored in break", brkCause, 9'h020);
    runStart = 1; step(); runStart = 0;
    chk(brkReq == 0, "R12 run start clears", brkReq, 0);
    chk(brkCause == 9'h020, "R14 survives run", brkCause, 9'h020);
    statusClr = 1; step(); statusClr = 0;
    chk(brkCause == 0, "R14 host clear", brkCause, 0);

    // R8 map and write protect
    newRun(9'h040); fetch(8'hF0);
    chk(brkCause == 9'h040, "R8 fetch past end", brkCause, 9'h040);
    newRun(9'h040); access(8'hF5, 0, 0, 0);
    chk(brkReq == 0, "R8 io ok", brkReq, 0);
    access(8'h90, 0, 0, 0);
    chk(brkCause == 9'h040, "R8 hole", brkCause, 9'h040);
    newRun(9'h080); access(8'h65, 0, 0, 0);
    chk(brkReq == 0, "R8 ro read", brkReq, 0);
    access(8'h65, 1, 0, 0);
    chk(brkCause == 9'h080, "R8 ro write", brkCause, 9'h080);

    // R9 stack window with widened top
    newRun(9'h100); access(8'h52, 1, 0, 1);
    chk(brkReq == 0, "R9 top plus three", brkReq, 0);
    access(8'h53, 1, 0, 1);
    chk(brkCause == 9'h100, "R9 above", brkCause, 9'h100);
    newRun(9'h100); access(8'h3F, 0, 0, 1);
    chk(brkCause == 9'h100, "R9 below", brkCause, 9'h100);

    // R10 disabled sources
    newRun(9'h0FE); fetch(8'h55); access(8'h53, 1, 0, 1);
    chk(brkReq == 0 && brkCause == 0, "R10 disabled", {brkReq, brkCause}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule